// File: doc/BRIEF.md
# FM Synthesis Register Write Pacer

This block sits between a slow 8-bit host bus and the register port of an FM synthesis chip. Each host cycle is decoded from two address bits. Bit 4 chooses between an address-select write and a data write, and bit 5 marks a status read. Every other address bit is ignored, so many host offsets alias onto the same three ports.

Writes do not go straight to the chip. They enter a small queue of {A0, data} entries. A pacer takes the entries out in order and drives a one-cycle chip strobe for each one. After each strobe it holds off all further chip operations for a number of chip master clock cycles, and that number depends on the kind of write. An address-select write is followed by a short gap (12 master clocks by default). A data write is followed by a long gap (84 by default). The master clock arrives as a one-cycle enable, `mclk_tick`.

The write side is a valid/ready stream. A write is taken on any cycle where `host_valid`, `host_we` and `host_ready` are all high. `host_ready` drops for writes while the queue is full, and `busy` mirrors that state so a host can poll it instead. When `host_ready` is low the host must hold the write and try again later.

Reads are always accepted. A status read jumps ahead of the queue, but it only reaches the chip when no gap is running. Every read answers exactly two cycles after it was accepted, and the answer is the latched status byte.

Top module: `fm_reg_pacer`

## Requirements
- R1: A host write is accepted exactly when `host_valid`, `host_we` and `host_ready` are all high. `host_ready` is low for a write only while the queue holds DEPTH entries, and `busy` is high exactly then. Reads always see `host_ready` high.
- R2: The chip's `chip_a0` during a write strobe equals host address bit 4 of that write: 0 means address-select and 1 means data. Host address bits other than 4 and 5 have no effect, and bit 5 has no effect on writes.
- R3: Queued writes reach the chip in acceptance order. Each one is a single cycle with `chip_cs_n` and `chip_wr_n` both low, and `chip_dout` carries the written byte.
- R4: After an address-select write is issued (A0 = 0), no chip operation is issued until ADDR_GAP master clock ticks have elapsed. With a tick on every cycle, two such strobes are ADDR_GAP+1 cycles apart.
- R5: After a data write is issued (A0 = 1), no chip operation is issued until DATA_GAP ticks have elapsed. With a tick on every cycle, the next strobe comes DATA_GAP+1 cycles later.
- R6: A read with address bit 5 set, accepted while no gap is pending, produces one cycle later a strobe with `chip_cs_n` and `chip_rd_n` both low and `chip_a0` equal to address bit 4. The chip's `chip_din` is latched during that strobe.
- R7: Every accepted read raises `host_rdata_valid` for one cycle, two cycles after acceptance, with `host_rdata` equal to the latched status. A read made during a gap, or with bit 5 clear, produces no strobe and returns the previously latched value.
- R8: When a status read can be issued and a queued write is also eligible in the same cycle, the read goes first and the write waits.
- R9: Synchronous reset empties the queue, clears the gap counter, and drives `chip_cs_n`, `chip_wr_n` and `chip_rd_n` high. After reset, `busy`, `host_rdata_valid`, `chip_a0`, `chip_dout` and the status latch are all 0.
- R10: Whenever `chip_cs_n` is low, exactly one of `chip_wr_n` and `chip_rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mclk_tick | input | 1 | One-cycle enable marking each chip master clock cycle |
| host_valid | input | 1 | Host cycle present (window selected during phi2) |
| host_ready | output | 1 | Write accepted this cycle; always high for reads |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host address; only bits 4 and 5 are decoded |
| host_wdata | input | 8 | Write byte |
| busy | output | 1 | Write queue full |
| host_rdata_valid | output | 1 | Read answer present |
| host_rdata | output | 8 | Latched chip status |
| chip_cs_n | output | 1 | Chip select, active low |
| chip_wr_n | output | 1 | Write strobe, active low |
| chip_rd_n | output | 1 | Read strobe, active low |
| chip_a0 | output | 1 | Chip port select |
| chip_dout | output | 8 | Byte written to the chip |
| chip_din | input | 8 | Status byte from the chip |

## Verification
The bench builds the block with DEPTH = 4, ADDR_GAP = 3 and DATA_GAP = 9. These values keep the strobe-to-strobe spacing short enough to measure directly for both gap lengths. They also let a burst of writes fill the queue and hold `busy` high within a few cycles. Finally, they make it common for a status read to arrive just as a gap expires while a write is waiting, which is the case where the read must go first. With irregular tick patterns, many reads land inside gaps and return the stale latched byte, and host addresses with random unused bits exercise the aliasing.

// File: rtl/fm_pace_pkg.sv
package fm_pace_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              a0;
    logic [DATA_W-1:0] data;
  } wr_entry_t;

  localparam int ENTRY_W = $bits(wr_entry_t);
endpackage

// File: rtl/fm_pace_fifo.sv
module fm_pace_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == FULLC);
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wptr] <= push_data;
        wptr      <= (wptr == LAST) ? '0 : wptr + 1'b1;
      end
      if (pop) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst) push |-> !full)
    else $error("queue overflow");
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst) pop |-> !empty)
    else $error("queue underflow");
endmodule

// File: rtl/fm_pace_gap.sv
module fm_pace_gap #(
  parameter int ADDR_GAP = 12,
  parameter int DATA_GAP = 84
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic load,
  input  logic load_long,
  output logic idle
);
  localparam int GMAX = (DATA_GAP > ADDR_GAP) ? DATA_GAP : ADDR_GAP;
  localparam int CW   = $clog2(GMAX + 1);

  logic [CW-1:0] cnt;

  assign idle = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= load_long ? CW'(DATA_GAP) : CW'(ADDR_GAP);
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (rst) (!load && !tick) |=> $stable(cnt))
    else $error("gap counter moved without tick");
  p_long_r5: assert property (@(posedge clk) disable iff (rst) (load && load_long) |=> !idle)
    else $error("data gap not started");
  p_short_r4: assert property (@(posedge clk) disable iff (rst) (load && !load_long) |=> !idle)
    else $error("address gap not started");
endmodule

// File: rtl/fm_reg_pacer.sv
module fm_reg_pacer #(
  parameter int ADDR_W   = 8,
  parameter int DEPTH    = 4,
  parameter int ADDR_GAP = 12,
  parameter int DATA_GAP = 84
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclk_tick,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic              busy,
  output logic              host_rdata_valid,
  output logic [7:0]        host_rdata,
  output logic              chip_cs_n,
  output logic              chip_wr_n,
  output logic              chip_rd_n,
  output logic              chip_a0,
  output logic [7:0]        chip_dout,
  input  logic [7:0]        chip_din
);
  import fm_pace_pkg::*;

  localparam int SEL_BIT  = 4;
  localparam int READ_BIT = 5;

  logic      is_wr, is_rd, push, pop, rd_go;
  logic      q_empty, q_full, gap_idle;
  wr_entry_t in_ent, head_ent;
  logic      rd_stage;
  logic [7:0] status_q;

  assign is_wr  = host_valid && host_we;
  assign is_rd  = host_valid && !host_we;
  assign host_ready = !host_we || !q_full;
  assign busy   = q_full;
  assign push   = is_wr && !q_full;
  assign in_ent = '{a0: host_addr[SEL_BIT], data: host_wdata};
  assign rd_go  = is_rd && host_addr[READ_BIT] && gap_idle;
  assign pop    = !q_empty && gap_idle && !rd_go;

  fm_pace_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_data(in_ent),
    .pop(pop), .head(head_ent),
    .empty(q_empty), .full(q_full)
  );

  fm_pace_gap #(.ADDR_GAP(ADDR_GAP), .DATA_GAP(DATA_GAP)) u_gap (
    .clk(clk), .rst(rst), .tick(mclk_tick),
    .load(pop), .load_long(head_ent.a0),
    .idle(gap_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_cs_n <= 1'b1;
      chip_wr_n <= 1'b1;
      chip_rd_n <= 1'b1;
      chip_a0   <= 1'b0;
      chip_dout <= '0;
    end else begin
      chip_cs_n <= 1'b1;
      chip_wr_n <= 1'b1;
      chip_rd_n <= 1'b1;
      if (rd_go) begin
        chip_cs_n <= 1'b0;
        chip_rd_n <= 1'b0;
        chip_a0   <= host_addr[SEL_BIT];
      end else if (pop) begin
        chip_cs_n <= 1'b0;
        chip_wr_n <= 1'b0;
        chip_a0   <= head_ent.a0;
        chip_dout <= head_ent.data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q         <= '0;
      rd_stage         <= 1'b0;
      host_rdata_valid <= 1'b0;
    end else begin
      if (!chip_cs_n && !chip_rd_n) status_q <= chip_din;
      rd_stage         <= is_rd;
      host_rdata_valid <= rd_stage;
    end
  end

  assign host_rdata = status_q;

  p_gap_block_r4: assert property (@(posedge clk) disable iff (rst) !gap_idle |-> (!pop && !rd_go))
    else $error("chip op issued inside gap");
  p_rd_first_r8: assert property (@(posedge clk) disable iff (rst) rd_go |=> (!chip_rd_n && chip_wr_n))
    else $error("read lost priority");
  p_strobe_pair_r10: assert property (@(posedge clk) disable iff (rst) !chip_cs_n |-> (chip_wr_n != chip_rd_n))
    else $error("bad strobe combination");
  p_rdv_r7: assert property (@(posedge clk) disable iff (rst) host_rdata_valid |-> $past(is_rd, 2))
    else $error("read answer without request");
  p_ready_r1: assert property (@(posedge clk) disable iff (rst) (is_wr && !q_full) |-> host_ready)
    else $error("write refused with room");
endmodule

// File: tb/fm_reg_pacer_bench.sv
module fm_reg_pacer_bench;
  localparam int DEPTH = 4;
  localparam int AG    = 3;
  localparam int DG    = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, valid = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, din = '0;
  logic host_ready, busy, rdv, cs_n, wr_n, rd_n, a0;
  logic [7:0] rdata, dout;

  always #2 clk = ~clk;

  fm_reg_pacer #(.ADDR_W(8), .DEPTH(DEPTH), .ADDR_GAP(AG), .DATA_GAP(DG)) u_fm_reg_pacer (
    .clk(clk), .rst(rst), .mclk_tick(tick),
    .host_valid(valid), .host_ready(host_ready), .host_we(we),
    .host_addr(addr), .host_wdata(wdata), .busy(busy),
    .host_rdata_valid(rdv), .host_rdata(rdata),
    .chip_cs_n(cs_n), .chip_wr_n(wr_n), .chip_rd_n(rd_n),
    .chip_a0(a0), .chip_dout(dout), .chip_din(din)
  );

  // behavioural reference
  logic [8:0] q[$];
  int   m_cnt;
  logic m_cs, m_wr, m_rd, m_a0, m_stage, m_rdv;
  logic [7:0] m_d, m_st;

  always @(posedge clk) begin : model
    bit rdgo, popit, pushit;
    logic [8:0] hd;
    if (rst) begin
      q.delete(); m_cnt = 0;
      m_cs = 1; m_wr = 1; m_rd = 1; m_a0 = 0; m_d = 0; m_st = 0;
      m_stage = 0; m_rdv = 0;
    end else begin
      if (!m_cs && !m_rd) m_st = din;
      m_rdv   = m_stage;
      m_stage = valid && !we;
      rdgo    = valid && !we && addr[5] && (m_cnt == 0);
      popit   = (q.size() > 0) && (m_cnt == 0) && !rdgo;
      pushit  = valid && we && (q.size() < DEPTH);
      m_cs = 1; m_wr = 1; m_rd = 1;
      if (rdgo) begin
        m_cs = 0; m_rd = 0; m_a0 = addr[4];
      end else if (popit) begin
        hd = q.pop_front();
        m_cs = 0; m_wr = 0; m_a0 = hd[8]; m_d = hd[7:0];
        m_cnt = hd[8] ? DG : AG;
      end else if (tick && m_cnt > 0) begin
        m_cnt--;
      end
      if (pushit) q.push_back({addr[4], wdata});
    end
  end

  int nvec = 0, nfail = 0, cyc = 0;
  int wr_t[$];
  logic wr_a[$];
  bit done = 0;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(logic v, logic w, logic [7:0] ad, logic [7:0] wd, logic tk);
    @(negedge clk);
    cyc++;
    valid = v; we = w; addr = ad; wdata = wd; tick = tk; din = 8'($urandom);
    #1;
    cmp("R1 host_ready", host_ready, !(w && q.size() == DEPTH));
    cmp("R1 busy", busy, q.size() == DEPTH);
    cmp("R3 chip_cs_n", cs_n, m_cs);
    cmp("R4 R5 chip_wr_n", wr_n, m_wr);
    cmp("R6 R8 chip_rd_n", rd_n, m_rd);
    cmp("R10 strobe pair", !cs_n ? 32'(wr_n ^ rd_n) : 32'd1, 32'd1);
    if (!m_cs) cmp("R2 chip_a0", a0, m_a0);
    if (!m_wr) cmp("R3 chip_dout", dout, m_d);
    cmp("R7 host_rdata_valid", rdv, m_rdv);
    if (m_rdv) cmp("R7 host_rdata", rdata, m_st);
    if (!wr_n) begin wr_t.push_back(cyc); wr_a.push_back(a0); end
  endtask

  task automatic idle(int n, logic tk);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 8'h00, tk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    bit saw_wr, saw_rd;
    idle(3, 0);
    rst = 1'b0;
    idle(1, 0);
    // R9 reset state
    cmp("R9 cs_n", cs_n, 1); cmp("R9 wr_n", wr_n, 1); cmp("R9 rd_n", rd_n, 1);
    cmp("R9 busy", busy, 0); cmp("R9 rdata_valid", rdv, 0);
    cmp("R9 a0", a0, 0); cmp("R9 dout", dout, 0); cmp("R9 rdata", rdata, 0);

    // R4 R5 R2: gap spacing with a tick every cycle, aliased addresses
    wr_t.delete(); wr_a.delete();
    step(1, 1, 8'hC3, 8'h11, 1);   // bit4=0: address select
    step(1, 1, 8'hBF, 8'h22, 1);   // bit4=1, bit5=1: data write (bit5 ignored)
    step(1, 1, 8'h0F, 8'h33, 1);   // bit4=0
    idle(30, 1);
    cmp("R3 strobe count", wr_t.size(), 3);
    if (wr_t.size() == 3) begin
      cmp("R4 addr gap", wr_t[1] - wr_t[0], AG + 1);
      cmp("R5 data gap", wr_t[2] - wr_t[1], DG + 1);
      cmp("R2 a0 first", wr_a[0], 0);
      cmp("R2 a0 second", wr_a[1], 1);
      cmp("R2 a0 third", wr_a[2], 0);
    end

    // R1: fill the queue while the gap holds, with no ticks
    step(1, 1, 8'h10, 8'hA0, 0);
    for (int i = 0; i < DEPTH + 2; i++) step(1, 1, 8'h00, 8'(i), 0);
    cmp("R1 busy when full", busy, 1);
    cmp("R1 ready low when full", host_ready, 0);
    idle(80, 1);

    // R8: a write waits in the queue behind a gap, a read is held until it issues
    step(1, 1, 8'h10, 8'h55, 1);
    idle(2, 1);
    step(1, 1, 8'h00, 8'h66, 1);
    saw_wr = 0; saw_rd = 0;
    for (int i = 0; i < 40 && !saw_rd; i++) begin
      step(1, 0, 8'h20, 8'h00, 1);
      if (!rd_n) saw_rd = 1;
      else if (!wr_n) saw_wr = 1;
    end
    cmp("R8 read issued", saw_rd, 1);
    cmp("R8 read before write", saw_wr, 0);
    // R7: a read with bit5 clear makes no strobe
    step(1, 0, 8'h10, 8'h00, 1);
    idle(1, 1);
    cmp("R7 no strobe for bit5 clear", rd_n, 1);
    idle(40, 1);

    // mixed random traffic, irregular ticks, aliased addresses
    for (int i = 0; i < 4000; i++) begin
      logic v, w, tk;
      v  = ($urandom % 3) != 0;
      w  = ($urandom % 2) != 0;
      tk = ($urandom % 3) == 0;
      step(v, w, 8'($urandom), 8'($urandom), tk);
    end
    idle(200, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule